// File: doc/BRIEF.md
# Interrupt Stack Frame Sequencer

This block carries out the memory side of interrupt entry and interrupt return for a processor whose code addresses are 22 bits wide: a 6-bit code segment plus a 16-bit offset. When a request is accepted, it takes a snapshot of the program counter, the flags, the code segment register, the interrupt segment register and the stack pointer. It then drives one stack byte write per cycle. A return request runs the mirror sequence: one stack byte read per cycle, followed by a single commit cycle that hands the restored values back to the register file.

A mode input is sampled when an entry is accepted and selects one of two frame layouts.

- **Compact frame.** Three bytes are pushed: the program counter and the flags. The code segment register is not touched. While the handler runs, the interrupt segment register supplies the active code segment, so the handler lives in a single 64 KB segment.
- **Extended frame.** The old code segment is pushed as a fourth byte. The interrupt segment value is then written into the code segment register, so the handler can reach the whole 4 MB space.

The block records the mode of every open frame in a small history stack. Each return therefore pops the layout that its own entry pushed. The history also drives the output that selects which segment register is active.

Top module: `isf_seq`

## Requirements
- R1: After reset `busy`, `stk_we`, `stk_re`, `sp_wr`, `pc_wr`, `flags_wr`, `csr_wr` and `act_seg_isr` are all 0, and `act_seg` equals `csr_in`.
- R2: A compact entry (mode 0) writes three bytes. Byte k goes to address `sp_in-1-k`, in the order PC[7:0], PC[15:8], flags. The commit cycle then pulses `sp_wr` with `sp_out = sp_in-3`, and `csr_wr` stays 0.
- R3: An extended entry (mode 1) writes the same three bytes followed by a fourth byte at `sp_in-4` that holds the code segment zero-extended to 8 bits. The commit cycle pulses `sp_wr` with `sp_out = sp_in-4`, and pulses `csr_wr` with `csr_out` equal to the sampled `isr_in`.
- R4: While the newest open frame is compact, `act_seg_isr` is 1 and `act_seg` follows `isr_in`. When no frame is open, or the newest one is extended, `act_seg_isr` is 0 and `act_seg` follows `csr_in`.
- R5: A return from a compact frame reads addresses `sp_in`, `sp_in+1` and `sp_in+2` as flags, PC[15:8] and PC[7:0]. The commit cycle pulses `pc_wr`, `flags_wr` and `sp_wr` with `sp_out = sp_in+3`, and `csr_wr` stays 0.
- R6: A return from an extended frame first reads the segment byte at `sp_in` (low 6 bits) and then continues as in R5. The commit cycle pulses `csr_wr` with the restored segment and gives `sp_out = sp_in+4`.
- R7: The mode is taken only in the accept cycle, so changes on `ext_mode` during a sequence have no effect. A return uses the mode recorded for the frame it closes, including when frames of both modes are nested.
- R8: `busy` is high from the cycle after acceptance through the commit cycle: 4 cycles for a compact frame and 5 for an extended frame, on both entry and return. Every stack strobe and every commit pulse falls inside that window.
- R9: A request that arrives while `busy` is high is held and served once the block is idle again. When an entry request and a return request are both waiting, the entry runs first.
- R10: A return request made while no frame is open is dropped. No bus cycle follows, and the request is not replayed after a later entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 1 | Interrupt entry request pulse |
| ret_req | input | 1 | Interrupt return request pulse |
| ext_mode | input | 1 | Frame mode: 0 compact, 1 extended |
| pc_in | input | 16 | Current program counter |
| flags_in | input | 8 | Current flags |
| csr_in | input | SEG_W | Current code segment register |
| isr_in | input | SEG_W | Interrupt segment register |
| sp_in | input | SP_W | Current stack pointer |
| stk_rdata | input | 8 | Stack read data, valid in the cycle `stk_re` is high |
| stk_we | output | 1 | Stack byte write strobe |
| stk_re | output | 1 | Stack byte read strobe |
| stk_addr | output | SP_W | Stack byte address |
| stk_wdata | output | 8 | Stack write data |
| busy | output | 1 | Sequence in progress |
| sp_wr | output | 1 | Stack pointer update strobe |
| sp_out | output | SP_W | New stack pointer |
| pc_wr | output | 1 | Program counter restore strobe |
| pc_out | output | 16 | Restored program counter |
| flags_wr | output | 1 | Flags restore strobe |
| flags_out | output | 8 | Restored flags |
| csr_wr | output | 1 | Code segment register load strobe |
| csr_out | output | SEG_W | New code segment value |
| act_seg_isr | output | 1 | Active code segment is taken from the interrupt segment register |
| act_seg | output | SEG_W | Active code segment value |

## Verification
The bench builds the block with SP_W=16, SEG_W=6 and NEST_DEPTH=4. At these values a full 16-bit stack address is exercised, including a push sequence that wraps below address zero. The segment byte carries two padding bits whose zero value can be checked. The history is deep enough to nest a compact frame under an extended one and back out. The bench stands in for the register file: it feeds every committed stack pointer back into `sp_in`. This lets held and back-to-back requests run on the true stack state.

// File: rtl/isf_pkg.sv
package isf_pkg;

    localparam int OFS_W  = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PUSH = 2'd1,
        ST_POP  = 2'd2,
        ST_FIN  = 2'd3
    } isf_state_e;

    typedef enum logic {
        FRM_COMPACT  = 1'b0,
        FRM_EXTENDED = 1'b1
    } frm_mode_e;

    // Slot number equals push order; pops walk the slots downward.
    typedef enum logic [1:0] {
        SLOT_PCL = 2'd0,
        SLOT_PCH = 2'd1,
        SLOT_FLG = 2'd2,
        SLOT_SEG = 2'd3
    } frm_slot_e;

    typedef struct packed {
        logic [OFS_W-1:0]  pc;
        logic [BYTE_W-1:0] flags;
    } isf_ctx_t;

    function automatic logic [1:0] frame_last(frm_mode_e m);
        return (m == FRM_EXTENDED) ? 2'd3 : 2'd2;
    endfunction

endpackage

// File: rtl/isf_mode_stack.sv
module isf_mode_stack
    import isf_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  frm_mode_e push_mode,
    input  logic      pop,
    output frm_mode_e top_mode,
    output logic      empty
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DEPTH-1:0] modes;
    logic [DEPTH-1:0] shift_dn;
    logic [DEPTH-1:0] shift_up;
    logic [CNT_W-1:0] cnt;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        if (i == 0) begin : g_head
            assign shift_dn[i] = push_mode;
        end else begin : g_body
            assign shift_dn[i] = modes[i-1];
        end
        if (i == DEPTH - 1) begin : g_tail
            assign shift_up[i] = 1'b0;
        end else begin : g_rest
            assign shift_up[i] = modes[i+1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            modes <= '0;
            cnt   <= '0;
        end else if (push) begin
            modes <= shift_dn;
            if (cnt != CNT_W'(DEPTH)) cnt <= cnt + 1'b1;
        end else if (pop) begin
            modes <= shift_up;
            if (cnt != '0) cnt <= cnt - 1'b1;
        end
    end

    assign top_mode = frm_mode_e'(modes[0]);
    assign empty    = (cnt == '0);
endmodule

// File: rtl/isf_frame_mux.sv
module isf_frame_mux
    import isf_pkg::*;
#(
    parameter int SEG_W = 6
) (
    input  frm_slot_e          slot,
    input  isf_ctx_t           ctx,
    input  logic [SEG_W-1:0]   seg,
    output logic [BYTE_W-1:0]  byte_out
);
    always_comb begin
        case (slot)
            SLOT_PCL: byte_out = ctx.pc[7:0];
            SLOT_PCH: byte_out = ctx.pc[15:8];
            SLOT_FLG: byte_out = ctx.flags;
            default:  byte_out = BYTE_W'(seg);
        endcase
    end
endmodule

// File: rtl/isf_seq.sv
module isf_seq
    import isf_pkg::*;
#(
    parameter int SP_W       = 16,
    parameter int SEG_W      = 6,
    parameter int NEST_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              irq_req,
    input  logic              ret_req,
    input  logic              ext_mode,
    input  logic [15:0]       pc_in,
    input  logic [7:0]        flags_in,
    input  logic [SEG_W-1:0]  csr_in,
    input  logic [SEG_W-1:0]  isr_in,
    input  logic [SP_W-1:0]   sp_in,
    input  logic [7:0]        stk_rdata,
    output logic              stk_we,
    output logic              stk_re,
    output logic [SP_W-1:0]   stk_addr,
    output logic [7:0]        stk_wdata,
    output logic              busy,
    output logic              sp_wr,
    output logic [SP_W-1:0]   sp_out,
    output logic              pc_wr,
    output logic [15:0]       pc_out,
    output logic              flags_wr,
    output logic [7:0]        flags_out,
    output logic              csr_wr,
    output logic [SEG_W-1:0]  csr_out,
    output logic              act_seg_isr,
    output logic [SEG_W-1:0]  act_seg
);
    localparam logic [SP_W-1:0] SP_ONE = SP_W'(1);

    isf_state_e        state;
    frm_mode_e         mode_r;
    logic              is_entry;
    logic [1:0]        step;
    logic [SP_W-1:0]   sp_r;
    isf_ctx_t          ctx_r;
    logic [SEG_W-1:0]  seg_r;
    logic [SEG_W-1:0]  isr_r;
    logic              irq_pend;
    logic              ret_pend;

    frm_mode_e         hist_top;
    logic              hist_empty;
    logic              take_irq;
    logic              take_ret;
    logic              drop_ret;
    logic              at_last;
    logic              fin;
    logic [1:0]        last_slot;
    frm_slot_e         cur_slot;

    assign last_slot = frame_last(mode_r);
    assign at_last   = (step == last_slot);
    assign cur_slot  = (state == ST_PUSH) ? frm_slot_e'(step)
                                          : frm_slot_e'(last_slot - step);

    assign take_irq = (state == ST_IDLE) && (irq_req || irq_pend);
    assign take_ret = (state == ST_IDLE) && !take_irq &&
                      (ret_req || ret_pend) && !hist_empty;
    assign drop_ret = (state == ST_IDLE) && !take_irq && hist_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            mode_r   <= FRM_COMPACT;
            is_entry <= 1'b0;
            step     <= '0;
            sp_r     <= '0;
            ctx_r    <= '0;
            seg_r    <= '0;
            isr_r    <= '0;
            irq_pend <= 1'b0;
            ret_pend <= 1'b0;
        end else begin
            irq_pend <= (irq_pend || irq_req) && !take_irq;
            ret_pend <= (ret_pend || ret_req) && !take_ret && !drop_ret;
            case (state)
                ST_IDLE: begin
                    step <= '0;
                    if (take_irq) begin
                        state       <= ST_PUSH;
                        is_entry    <= 1'b1;
                        mode_r      <= frm_mode_e'(ext_mode);
                        sp_r        <= sp_in;
                        ctx_r.pc    <= pc_in;
                        ctx_r.flags <= flags_in;
                        seg_r       <= csr_in;
                        isr_r       <= isr_in;
                    end else if (take_ret) begin
                        state    <= ST_POP;
                        is_entry <= 1'b0;
                        mode_r   <= hist_top;
                        sp_r     <= sp_in;
                    end
                end
                ST_PUSH: begin
                    sp_r <= sp_r - SP_ONE;
                    step <= step + 1'b1;
                    if (at_last) state <= ST_FIN;
                end
                ST_POP: begin
                    sp_r <= sp_r + SP_ONE;
                    step <= step + 1'b1;
                    case (cur_slot)
                        SLOT_PCL: ctx_r.pc[7:0]  <= stk_rdata;
                        SLOT_PCH: ctx_r.pc[15:8] <= stk_rdata;
                        SLOT_FLG: ctx_r.flags    <= stk_rdata;
                        default:  seg_r          <= stk_rdata[SEG_W-1:0];
                    endcase
                    if (at_last) state <= ST_FIN;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign fin = (state == ST_FIN);

    isf_mode_stack #(.DEPTH(NEST_DEPTH)) u_hist (
        .clk       (clk),
        .rst       (rst),
        .push      (fin && is_entry),
        .push_mode (mode_r),
        .pop       (fin && !is_entry),
        .top_mode  (hist_top),
        .empty     (hist_empty)
    );

    isf_frame_mux #(.SEG_W(SEG_W)) u_mux (
        .slot     (cur_slot),
        .ctx      (ctx_r),
        .seg      (seg_r),
        .byte_out (stk_wdata)
    );

    assign stk_we   = (state == ST_PUSH);
    assign stk_re   = (state == ST_POP);
    assign stk_addr = stk_we ? (sp_r - SP_ONE) : sp_r;
    assign busy     = (state != ST_IDLE);

    assign sp_wr     = fin;
    assign sp_out    = sp_r;
    assign pc_wr     = fin && !is_entry;
    assign pc_out    = ctx_r.pc;
    assign flags_wr  = fin && !is_entry;
    assign flags_out = ctx_r.flags;
    assign csr_wr    = fin && (mode_r == FRM_EXTENDED);
    assign csr_out   = is_entry ? isr_r : seg_r;

    assign act_seg_isr = !hist_empty && (hist_top == FRM_COMPACT);
    assign act_seg     = act_seg_isr ? isr_in : csr_in;
endmodule

// File: rtl/isf_seq_chk.sv
module isf_seq_chk #(
    parameter int SP_W       = 16,
    parameter int SEG_W      = 6,
    parameter int NEST_DEPTH = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [SP_W-1:0]  sp_in,
    input logic             stk_we,
    input logic             stk_re,
    input logic [SP_W-1:0]  stk_addr,
    input logic             busy,
    input logic             sp_wr,
    input logic             pc_wr,
    input logic             csr_wr
);
    // R8: every bus strobe and commit pulse sits inside the busy window
    a_r8_strobes_in_busy: assert property (@(posedge clk) disable iff (rst)
        (stk_we || stk_re || sp_wr) |-> busy);

    // R8: busy only drops after a commit cycle
    a_r8_busy_ends_on_commit: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(sp_wr));

    // R2: writes and reads never overlap
    a_r2_bus_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(stk_we && stk_re));

    // R2: the first push lands just below the sampled stack pointer
    a_r2_first_push: assert property (@(posedge clk) disable iff (rst)
        $rose(stk_we) |-> (stk_addr == SP_W'($past(sp_in) - 1'b1)));

    // R3: consecutive pushes descend by one byte
    a_r3_push_descends: assert property (@(posedge clk) disable iff (rst)
        (stk_we && $past(stk_we)) |-> (stk_addr == SP_W'($past(stk_addr) - 1'b1)));

    // R5: the first pop reads at the sampled stack pointer
    a_r5_first_pop: assert property (@(posedge clk) disable iff (rst)
        $rose(stk_re) |-> (stk_addr == $past(sp_in)));

    // R6: consecutive pops ascend by one byte
    a_r6_pop_ascends: assert property (@(posedge clk) disable iff (rst)
        (stk_re && $past(stk_re)) |-> (stk_addr == SP_W'($past(stk_addr) + 1'b1)));

    // R5: restore strobes only come with a stack pointer commit
    a_r5_commit_together: assert property (@(posedge clk) disable iff (rst)
        (pc_wr || csr_wr) |-> sp_wr);
endmodule

bind isf_seq isf_seq_chk #(
    .SP_W(SP_W), .SEG_W(SEG_W), .NEST_DEPTH(NEST_DEPTH)
) u_chk (
    .clk(clk), .rst(rst), .sp_in(sp_in), .stk_we(stk_we), .stk_re(stk_re),
    .stk_addr(stk_addr), .busy(busy), .sp_wr(sp_wr), .pc_wr(pc_wr), .csr_wr(csr_wr)
);

// File: tb/isf_seq_tb.sv
module isf_seq_tb;
    localparam int SP_W       = 16;
    localparam int SEG_W      = 6;
    localparam int NEST_DEPTH = 4;

    // {ext, pc, flags, csr, isr, sp}
    localparam logic [52:0] VECS [4] = '{
        {1'b0, 16'h1234, 8'hA5, 6'h05, 6'h2A, 16'h0080},
        {1'b1, 16'hBEEF, 8'h3C, 6'h11, 6'h3F, 16'h0100},
        {1'b1, 16'h00FF, 8'h00, 6'h3E, 6'h01, 16'h0002},
        {1'b0, 16'hFF00, 8'hFF, 6'h00, 6'h15, 16'h0041}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic irq_req = 1'b0, ret_req = 1'b0, ext_mode = 1'b0;
    logic [15:0] pc_in = '0;
    logic [7:0]  flags_in = '0;
    logic [SEG_W-1:0] csr_in = '0, isr_in = '0;
    logic [SP_W-1:0]  sp_in;
    logic [7:0]  stk_rdata;
    logic stk_we, stk_re, busy, sp_wr, pc_wr, flags_wr, csr_wr, act_seg_isr;
    logic [SP_W-1:0] stk_addr, sp_out;
    logic [7:0] stk_wdata, flags_out;
    logic [15:0] pc_out;
    logic [SEG_W-1:0] csr_out, act_seg;

    always #4 clk = ~clk;

    isf_seq #(.SP_W(SP_W), .SEG_W(SEG_W), .NEST_DEPTH(NEST_DEPTH)) u_dut (
        .clk(clk), .rst(rst), .irq_req(irq_req), .ret_req(ret_req), .ext_mode(ext_mode),
        .pc_in(pc_in), .flags_in(flags_in), .csr_in(csr_in), .isr_in(isr_in),
        .sp_in(sp_in), .stk_rdata(stk_rdata), .stk_we(stk_we), .stk_re(stk_re),
        .stk_addr(stk_addr), .stk_wdata(stk_wdata), .busy(busy), .sp_wr(sp_wr),
        .sp_out(sp_out), .pc_wr(pc_wr), .pc_out(pc_out), .flags_wr(flags_wr),
        .flags_out(flags_out), .csr_wr(csr_wr), .csr_out(csr_out),
        .act_seg_isr(act_seg_isr), .act_seg(act_seg)
    );

    // Stack memory, bus log and stack pointer register model
    logic [7:0]      mem [256];
    logic [SP_W-1:0] w_addr [8];
    logic [7:0]      w_data [8];
    int              wn, rn, bcnt, csr_n;
    logic [1:0]      first_kind;
    logic [SP_W-1:0] last_sp, sp_reg, sp_set;
    logic [15:0]     last_pc;
    logic [7:0]      last_flags;
    logic [SEG_W-1:0] last_csr;
    logic            clr = 1'b0, sp_ld = 1'b0;

    assign stk_rdata = mem[stk_addr[7:0]];
    assign sp_in     = sp_reg;

    always @(posedge clk) begin
        if (sp_ld) sp_reg <= sp_set;
        else if (sp_wr) sp_reg <= sp_out;
        if (stk_we) mem[stk_addr[7:0]] <= stk_wdata;
        if (clr) begin
            wn <= 0; rn <= 0; bcnt <= 0; csr_n <= 0; first_kind <= 2'd0;
        end else begin
            if (stk_we) begin
                w_addr[wn[2:0]] <= stk_addr;
                w_data[wn[2:0]] <= stk_wdata;
                wn <= wn + 1;
                if (first_kind == 2'd0) first_kind <= 2'd1;
            end
            if (stk_re) begin
                rn <= rn + 1;
                if (first_kind == 2'd0) first_kind <= 2'd2;
            end
            if (busy) bcnt <= bcnt + 1;
            if (sp_wr) last_sp <= sp_out;
            if (csr_wr) begin csr_n <= csr_n + 1; last_csr <= csr_out; end
            if (pc_wr) last_pc <= pc_out;
            if (flags_wr) last_flags <= flags_out;
        end
    end

    int nchk = 0, nfail = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic clear_log();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    task automatic set_sp(input logic [SP_W-1:0] v);
        @(negedge clk); sp_ld = 1'b1; sp_set = v;
        @(negedge clk); sp_ld = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (!busy) break;
        end
    endtask

    // Pulse an entry request; flip the mode right after acceptance (R7)
    task automatic run_irq(input logic ext);
        @(negedge clk); irq_req = 1'b1; ext_mode = ext;
        @(negedge clk); irq_req = 1'b0; ext_mode = !ext;
        wait_idle();
        ext_mode = 1'b0;
    endtask

    task automatic run_ret();
        @(negedge clk); ret_req = 1'b1; ext_mode = 1'b1;
        @(negedge clk); ret_req = 1'b0; ext_mode = 1'b0;
        wait_idle();
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; sp_ld = 1'b1; sp_set = '0; clr = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0; sp_ld = 1'b0; clr = 1'b0;
    endtask

    function automatic logic [7:0] exp_byte(input logic [15:0] pc, input logic [7:0] fl,
                                            input logic [SEG_W-1:0] cs, input int k);
        case (k)
            0: return pc[7:0];
            1: return pc[15:8];
            2: return fl;
            default: return 8'(cs);
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog R8 act=hung exp=idle");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state
        chk("R1 busy", busy, 0);
        chk("R1 strobes", {stk_we, stk_re, sp_wr, pc_wr, flags_wr, csr_wr}, 0);
        chk("R1 act_seg_isr", act_seg_isr, 0);
        csr_in = 6'h2B;
        #1 chk("R1 act_seg", act_seg, 6'h2B);

        // Vector table: entry then return per row (R2 R3 R5 R6 R7 R8 R4)
        for (int v = 0; v < 4; v++) begin
            logic ext; logic [15:0] pc; logic [7:0] fl;
            logic [SEG_W-1:0] cs, is; logic [SP_W-1:0] sp; int n;
            string rq;
            {ext, pc, fl, cs, is, sp} = VECS[v];
            n  = ext ? 4 : 3;
            rq = ext ? "R3" : "R2";
            set_sp(sp);
            @(negedge clk); pc_in = pc; flags_in = fl; csr_in = cs; isr_in = is;
            clear_log();
            run_irq(ext);
            chk({rq, " R7 push count"}, wn, n);
            for (int k = 0; k < n; k++) begin
                chk({rq, " push addr"}, w_addr[k], SP_W'(sp - SP_W'(k + 1)));
                chk({rq, " push data"}, w_data[k], exp_byte(pc, fl, cs, k));
            end
            chk({rq, " sp_out"}, last_sp, SP_W'(sp - SP_W'(n)));
            chk({rq, " csr writes"}, csr_n, ext ? 1 : 0);
            if (ext) chk("R3 csr_out", last_csr, is);
            chk("R8 entry busy cycles", bcnt, n + 1);
            chk("R4 act_seg_isr", act_seg_isr, !ext);
            chk("R4 act_seg", act_seg, ext ? cs : is);
            // Register file update and clobbered live values
            if (ext) csr_in = is;
            pc_in = 16'h0BAD; flags_in = 8'h77;
            clear_log();
            run_ret();
            chk(ext ? "R6 pop count" : "R5 pop count", rn, n);
            chk(ext ? "R6 pc" : "R5 pc", last_pc, pc);
            chk(ext ? "R6 flags" : "R5 flags", last_flags, fl);
            chk(ext ? "R6 sp" : "R5 sp", last_sp, sp);
            chk(ext ? "R6 csr writes" : "R5 csr writes", csr_n, ext ? 1 : 0);
            if (ext) chk("R6 csr restore", last_csr, cs);
            chk("R8 return busy cycles", bcnt, n + 1);
            chk("R4 closed act_seg_isr", act_seg_isr, 0);
        end

        // R10: return with no open frame is dropped
        do_reset();
        set_sp(16'h0060);
        clear_log();
        @(negedge clk); ret_req = 1'b1;
        @(negedge clk); ret_req = 1'b0;
        repeat (4) @(negedge clk);
        chk("R10 busy cycles", bcnt, 0);
        chk("R10 reads", rn, 0);
        pc_in = 16'h4455; flags_in = 8'h12;
        run_irq(1'b0);
        repeat (6) @(negedge clk);
        chk("R10 no replay reads", rn, 0);
        chk("R10 entry writes", wn, 3);
        run_ret();

        // R9: return held while an entry is busy
        do_reset();
        set_sp(16'h0080);
        pc_in = 16'hCAFE; flags_in = 8'h5A;
        clear_log();
        @(negedge clk); irq_req = 1'b1;
        @(negedge clk); irq_req = 1'b0; ret_req = 1'b1;
        @(negedge clk); ret_req = 1'b0;
        wait_idle();
        @(negedge clk);
        wait_idle();
        chk("R9 held writes", wn, 3);
        chk("R9 held reads", rn, 3);
        chk("R9 held pc", last_pc, 16'hCAFE);
        chk("R9 held sp", last_sp, 16'h0080);

        // R9: entry wins when both wait
        pc_in = 16'h1111;
        run_irq(1'b0);
        pc_in = 16'h2222; flags_in = 8'h99;
        clear_log();
        @(negedge clk); irq_req = 1'b1; ret_req = 1'b1;
        @(negedge clk); irq_req = 1'b0; ret_req = 1'b0;
        wait_idle();
        @(negedge clk);
        wait_idle();
        chk("R9 priority first is write", first_kind, 2'd1);
        chk("R9 priority pc", last_pc, 16'h2222);
        chk("R9 priority sp", last_sp, 16'h007D);

        // R7: nested extended frame over compact frame
        do_reset();
        set_sp(16'h0080);
        csr_in = 6'h05; isr_in = 6'h2A; pc_in = 16'hA1A1; flags_in = 8'h01;
        run_irq(1'b0);
        chk("R7 compact open", act_seg_isr, 1);
        pc_in = 16'hB2B2; flags_in = 8'h02;
        clear_log();
        run_irq(1'b1);
        chk("R7 nested writes", wn, 4);
        chk("R7 nested seg byte", w_data[3], 8'h05);
        chk("R7 extended on top", act_seg_isr, 0);
        csr_in = 6'h2A;
        clear_log();
        run_ret();
        chk("R7 ext return reads", rn, 4);
        chk("R7 ext return csr", last_csr, 6'h05);
        chk("R7 ext return pc", last_pc, 16'hB2B2);
        csr_in = 6'h05;
        chk("R7 compact back on top", act_seg_isr, 1);
        clear_log();
        run_ret();
        chk("R7 compact return reads", rn, 3);
        chk("R7 compact return csr writes", csr_n, 0);
        chk("R7 compact return pc", last_pc, 16'hA1A1);
        chk("R7 compact return sp", last_sp, 16'h0080);

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule